// File: doc/BRIEF.md
# Masked Wavefront Vector Execution Unit

This unit runs a small vector instruction set over a wavefront of 64 integer elements on a datapath that is only 16 lanes wide. Each vector instruction therefore occupies four consecutive cycles, one group of 16 elements per cycle. Every element has a bit in a 64-bit execution mask. A vector instruction changes only the elements whose mask bit is set.

Divergent if/else code is expressed as explicit mask operations rather than a hardware predicate stack. A signed greater-than compare fills a 64-bit condition mask. An "if" operation parks the current execution mask in a scalar slot and narrows the mask to the lanes whose condition bit is set. An "else" operation turns on the lanes that were parked but left out of the "if". A restore operation rejoins all lanes. A skip-branch reports its target when no lane is active, so that a fetch stage can jump over a body that no lane would run.

Instructions enter through a valid/ready handshake. A combinational read port exposes any element of any vector register.

Top module: `wave_simd_unit`

## Requirements
- R1: After reset, exec_mask is all ones, vcc_mask is all zeros, in_ready is 1 and branch_taken is 0.
- R2: An instruction is accepted on a rising edge where in_valid and in_ready are both 1. After a vector instruction (opcodes 1 to 5) is accepted, in_ready is 0 for the next three cycles. Another instruction can be accepted on the fourth edge after acceptance. Scalar instructions (opcodes 6 to 9) and opcode 0 leave in_ready at 1. exec_mask does not change while a vector instruction is in flight.
- R3: Opcode 1 sets bit e of vcc_mask to 1 exactly when element e is active and register va is greater than register vb at element e, compared as signed 32-bit values. Element e is handled in group e/16, at lane e%16.
- R4: Opcode 2 writes va minus vb, modulo 2^32, into register vd, only at elements whose exec_mask bit is 1.
- R5: Opcode 3 writes the low 32 bits of va times vb into vd, only at active elements.
- R6: Opcode 4 writes in_imm into vd at active elements. Opcode 5 writes the element index plus in_imm into vd at active elements. Inactive elements keep their value.
- R7: Opcode 6 copies exec_mask into scalar slot in_sd, then sets exec_mask to exec_mask AND vcc_mask. Both changes are visible one edge after acceptance.
- R8: Opcode 7 sets exec_mask to slot in_sd AND NOT exec_mask.
- R9: Opcode 8 copies slot in_sd into exec_mask.
- R10: Opcode 9 raises branch_taken for exactly one cycle after acceptance if exec_mask was all zeros at acceptance. branch_target then holds in_target. Otherwise branch_taken stays 0.
- R11: vcc_mask keeps its old value during a compare and takes all 64 new bits on the edge that ends the fourth group. An opcode 6 accepted on that same edge ANDs with the new bits.
- R12: rd_data shows element rd_lane of vector register rd_vreg combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_op | input | 4 | Opcode |
| in_vd | input | 2 | Destination vector register |
| in_va | input | 2 | First source vector register |
| in_vb | input | 2 | Second source vector register |
| in_sd | input | 2 | Scalar mask slot |
| in_imm | input | 32 | Immediate for the fill opcodes |
| in_target | input | 8 | Branch target for opcode 9 |
| branch_taken | output | 1 | One-cycle pulse: skip-branch taken |
| branch_target | output | 8 | Target of the last skip-branch |
| exec_mask | output | 64 | Execution mask |
| vcc_mask | output | 64 | Condition mask |
| rd_vreg | input | 2 | Read port register select |
| rd_lane | input | 6 | Read port element select |
| rd_data | output | 32 | Read port data |

## Verification
A compare's commit of the condition mask and an "if" operation can fall on the same edge, because in_ready rises during the compare's last group. The bench provokes this by presenting the "if" while the compare is still running, so that the "if" is accepted at the earliest legal edge. It judges the result in two ways. vcc_mask must still show the old bits in the middle of the compare. The narrowed exec_mask must equal the freshly compared bits, not the stale ones.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_VCMPGT   = 4'd1,
    OP_VSUB     = 4'd2,
    OP_VMUL     = 4'd3,
    OP_VIMM     = 4'd4,
    OP_VIDX     = 4'd5,
    OP_SIFSAVE  = 4'd6,
    OP_SELSE    = 4'd7,
    OP_SRESTORE = 4'd8,
    OP_SBRZ     = 4'd9
  } op_e;

  function automatic logic is_vec(op_e op);
    return op inside {OP_VCMPGT, OP_VSUB, OP_VMUL, OP_VIMM, OP_VIDX};
  endfunction

  function automatic logic writes_vreg(op_e op);
    return op inside {OP_VSUB, OP_VMUL, OP_VIMM, OP_VIDX};
  endfunction

  function automatic logic signed_gt(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic [WORD_W-1:0] lane_calc(op_e op, logic [WORD_W-1:0] a,
                                                  logic [WORD_W-1:0] b,
                                                  logic [WORD_W-1:0] imm,
                                                  logic [WORD_W-1:0] elem);
    logic [2*WORD_W-1:0] prod;
    prod = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
    case (op)
      OP_VSUB: return a - b;
      OP_VMUL: return prod[WORD_W-1:0];
      OP_VIMM: return imm;
      OP_VIDX: return elem + imm;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/wsu_vrf.sv
module wsu_vrf import wsu_pkg::*; #(
  parameter int NREG  = 4,
  parameter int WAVE  = 64,
  parameter int LANES = 16,
  localparam int RW = $clog2(NREG),
  localparam int GW = $clog2(WAVE / LANES),
  localparam int LW = $clog2(LANES),
  localparam int EW = $clog2(WAVE)
) (
  input  logic                          clk,
  input  logic [GW-1:0]                 grp,
  input  logic [RW-1:0]                 ra,
  input  logic [RW-1:0]                 rb,
  input  logic [RW-1:0]                 wr_reg,
  input  logic [LANES-1:0]              wr_en,
  input  logic [LANES-1:0][WORD_W-1:0]  wr_data,
  output logic [LANES-1:0][WORD_W-1:0]  a_grp,
  output logic [LANES-1:0][WORD_W-1:0]  b_grp,
  input  logic [RW-1:0]                 peek_reg,
  input  logic [EW-1:0]                 peek_elem,
  output logic [WORD_W-1:0]             peek_data
);
  logic [WORD_W-1:0] mem [NREG][WAVE];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en[i]) mem[wr_reg][{grp, LW'(i)}] <= wr_data[i];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      a_grp[i] = mem[ra][{grp, LW'(i)}];
      b_grp[i] = mem[rb][{grp, LW'(i)}];
    end
  end

  assign peek_data = mem[peek_reg][peek_elem];
endmodule

// File: rtl/wsu_lane.sv
module wsu_lane import wsu_pkg::*; #(
  parameter int IDX_W = 6
) (
  input  op_e               op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] imm,
  input  logic [IDX_W-1:0]  elem,
  input  logic              active,
  output logic [WORD_W-1:0] result,
  output logic              hit
);
  assign result = lane_calc(op, a, b, imm, WORD_W'(elem));
  assign hit    = active && signed_gt(a, b);
endmodule

// File: rtl/wsu_mask.sv
module wsu_mask import wsu_pkg::*; #(
  parameter int WAVE  = 64,
  parameter int LANES = 16,
  parameter int NSREG = 4,
  parameter int TGT_W = 8,
  localparam int GW = $clog2(WAVE / LANES),
  localparam int LW = $clog2(LANES),
  localparam int SW = $clog2(NSREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_fire,
  input  op_e              s_op,
  input  logic [SW-1:0]    s_idx,
  input  logic [TGT_W-1:0] s_target,
  input  logic             cmp_step,
  input  logic             cmp_last,
  input  logic [GW-1:0]    grp,
  input  logic [LANES-1:0] cmp_bits,
  output logic [WAVE-1:0]  exec_q,
  output logic [WAVE-1:0]  vcc_q,
  output logic             br_taken,
  output logic [TGT_W-1:0] br_target
);
  logic [WAVE-1:0] stage, vcc_new, vcc_eff;
  logic [WAVE-1:0] sreg [NSREG];
  logic if_fire, else_fire, rest_fire, brz_fire;

  assign if_fire   = s_fire && (s_op == OP_SIFSAVE);
  assign else_fire = s_fire && (s_op == OP_SELSE);
  assign rest_fire = s_fire && (s_op == OP_SRESTORE);
  assign brz_fire  = s_fire && (s_op == OP_SBRZ);

  always_comb begin
    vcc_new = stage;
    vcc_new[{grp, LW'(0)} +: LANES] = cmp_bits;
  end

  // forward a commit landing on the same edge as an "if"
  assign vcc_eff = cmp_last ? vcc_new : vcc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q    <= '1;
      vcc_q     <= '0;
      stage     <= '0;
      br_taken  <= 1'b0;
      br_target <= '0;
      for (int k = 0; k < NSREG; k++) sreg[k] <= '0;
    end else begin
      br_taken <= 1'b0;
      if (cmp_step) stage[{grp, LW'(0)} +: LANES] <= cmp_bits;
      if (cmp_last) vcc_q <= vcc_new;
      if (if_fire) begin
        sreg[s_idx] <= exec_q;
        exec_q      <= exec_q & vcc_eff;
      end
      if (else_fire) exec_q <= sreg[s_idx] & ~exec_q;
      if (rest_fire) exec_q <= sreg[s_idx];
      if (brz_fire) begin
        br_taken  <= (exec_q == '0);
        br_target <= s_target;
      end
    end
  end

  assert_if_narrows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    if_fire |=> (exec_q & ~$past(exec_q)) == '0);
  assert_else_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    else_fire |=> (exec_q & $past(exec_q)) == '0);
  assert_branch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> ($past(brz_fire) && $past(exec_q) == '0));
  assert_vcc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_last |=> $stable(vcc_q));
  assert_if_uses_new_vcc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (if_fire && cmp_last) |=> (exec_q & ~vcc_q) == '0);
endmodule

// File: rtl/wave_simd_unit.sv
module wave_simd_unit import wsu_pkg::*; #(
  parameter int LANES = 16,
  parameter int WAVE  = 64,
  parameter int NVREG = 4,
  parameter int NSREG = 4,
  parameter int TGT_W = 8,
  localparam int GROUPS = WAVE / LANES,
  localparam int GW = $clog2(GROUPS),
  localparam int LW = $clog2(LANES),
  localparam int EW = $clog2(WAVE),
  localparam int RW = $clog2(NVREG),
  localparam int SW = $clog2(NSREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [RW-1:0]     in_vd,
  input  logic [RW-1:0]     in_va,
  input  logic [RW-1:0]     in_vb,
  input  logic [SW-1:0]     in_sd,
  input  logic [WORD_W-1:0] in_imm,
  input  logic [TGT_W-1:0]  in_target,
  output logic              branch_taken,
  output logic [TGT_W-1:0]  branch_target,
  output logic [WAVE-1:0]   exec_mask,
  output logic [WAVE-1:0]   vcc_mask,
  input  logic [RW-1:0]     rd_vreg,
  input  logic [EW-1:0]     rd_lane,
  output logic [WORD_W-1:0] rd_data
);
  op_e in_op_e, cur_op;
  logic busy, last_grp, accept, vec_fire, scal_fire, cmp_step, cmp_last;
  logic [GW-1:0] grp;
  logic [RW-1:0] cur_vd, cur_va, cur_vb;
  logic [WORD_W-1:0] cur_imm;
  logic [LANES-1:0][WORD_W-1:0] a_grp, b_grp, res_grp;
  logic [LANES-1:0] wr_en, hit_grp;

  assign in_op_e   = op_e'(in_op);
  assign last_grp  = busy && (grp == GW'(GROUPS - 1));
  assign in_ready  = !busy || last_grp;
  assign accept    = in_valid && in_ready;
  assign vec_fire  = accept && is_vec(in_op_e);
  assign scal_fire = accept && !is_vec(in_op_e);
  assign cmp_step  = busy && (cur_op == OP_VCMPGT);
  assign cmp_last  = cmp_step && last_grp;

  // group sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      grp     <= '0;
      cur_op  <= OP_NOP;
      cur_vd  <= '0;
      cur_va  <= '0;
      cur_vb  <= '0;
      cur_imm <= '0;
    end else if (vec_fire) begin
      busy    <= 1'b1;
      grp     <= '0;
      cur_op  <= in_op_e;
      cur_vd  <= in_vd;
      cur_va  <= in_va;
      cur_vb  <= in_vb;
      cur_imm <= in_imm;
    end else if (last_grp) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (busy) begin
      grp <= grp + 1'b1;
    end
  end

  wsu_vrf #(.NREG(NVREG), .WAVE(WAVE), .LANES(LANES)) u_vrf (
    .clk(clk), .grp(grp), .ra(cur_va), .rb(cur_vb), .wr_reg(cur_vd),
    .wr_en(wr_en), .wr_data(res_grp), .a_grp(a_grp), .b_grp(b_grp),
    .peek_reg(rd_vreg), .peek_elem(rd_lane), .peek_data(rd_data)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LW-1:0] SLOT = LW'(i);
    logic [EW-1:0] elem;
    logic act;
    assign elem     = {grp, SLOT};
    assign act      = exec_mask[elem];
    assign wr_en[i] = busy && writes_vreg(cur_op) && act;
    wsu_lane #(.IDX_W(EW)) u_lane (
      .op(cur_op), .a(a_grp[i]), .b(b_grp[i]), .imm(cur_imm), .elem(elem),
      .active(act), .result(res_grp[i]), .hit(hit_grp[i])
    );
  end

  wsu_mask #(.WAVE(WAVE), .LANES(LANES), .NSREG(NSREG), .TGT_W(TGT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .s_fire(scal_fire), .s_op(in_op_e), .s_idx(in_sd),
    .s_target(in_target), .cmp_step(cmp_step), .cmp_last(cmp_last), .grp(grp),
    .cmp_bits(hit_grp), .exec_q(exec_mask), .vcc_q(vcc_mask),
    .br_taken(branch_taken), .br_target(branch_target)
  );

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |=> !in_ready);
  assert_exec_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_grp) |=> $stable(exec_mask));
endmodule

// File: tb/sim_wave_simd_unit.sv
`timescale 1ns/1ps
module sim_wave_simd_unit;
  localparam logic [3:0] K_NOP = 4'd0, K_CMP = 4'd1, K_SUB = 4'd2, K_MUL = 4'd3,
                         K_IMM = 4'd4, K_IDX = 4'd5, K_IF = 4'd6, K_ELSE = 4'd7,
                         K_REST = 4'd8, K_BRZ = 4'd9;

  logic clk, rst_n, in_valid, in_ready, branch_taken;
  logic [3:0] in_op;
  logic [1:0] in_vd, in_va, in_vb, in_sd, rd_vreg;
  logic [31:0] in_imm, rd_data;
  logic [7:0] in_target, branch_target;
  logic [63:0] exec_mask, vcc_mask;
  logic [5:0] rd_lane;
  int errors = 0, checks = 0;
  bit done = 0;

  wave_simd_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb), .in_sd(in_sd), .in_imm(in_imm),
    .in_target(in_target), .branch_taken(branch_taken), .branch_target(branch_target),
    .exec_mask(exec_mask), .vcc_mask(vcc_mask), .rd_vreg(rd_vreg), .rd_lane(rd_lane),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // entry: op | vd | va | vb | sd | imm | kind(1 exec,2 vcc,3 lane of vd) | lane | expected
  localparam int NT = 19;
  localparam logic [115:0] PROG [NT] = '{
    {K_IDX,  2'd0, 2'd0, 2'd0, 2'd0, 32'd0,        2'd0, 6'd0,  64'd0},
    {K_IMM,  2'd1, 2'd0, 2'd0, 2'd0, 32'd20,       2'd0, 6'd0,  64'd0},
    {K_CMP,  2'd0, 2'd0, 2'd1, 2'd0, 32'd0,        2'd2, 6'd0,  64'hFFFF_FFFF_FFE0_0000},
    {K_IF,   2'd0, 2'd0, 2'd0, 2'd0, 32'd0,        2'd1, 6'd0,  64'hFFFF_FFFF_FFE0_0000},
    {K_SUB,  2'd2, 2'd0, 2'd1, 2'd0, 32'd0,        2'd3, 6'd30, 64'd10},
    {K_MUL,  2'd2, 2'd2, 2'd0, 2'd0, 32'd0,        2'd3, 6'd30, 64'd300},
    {K_CMP,  2'd0, 2'd1, 2'd0, 2'd0, 32'd0,        2'd2, 6'd0,  64'd0},
    {K_ELSE, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0,        2'd1, 6'd0,  64'h0000_0000_001F_FFFF},
    {K_SUB,  2'd2, 2'd1, 2'd0, 2'd0, 32'd0,        2'd3, 6'd5,  64'd15},
    {K_MUL,  2'd2, 2'd2, 2'd1, 2'd0, 32'd0,        2'd3, 6'd5,  64'd300},
    {K_NOP,  2'd2, 2'd0, 2'd0, 2'd0, 32'd0,        2'd3, 6'd30, 64'd300},
    {K_NOP,  2'd2, 2'd0, 2'd0, 2'd0, 32'd0,        2'd3, 6'd19, 64'd20},
    {K_NOP,  2'd2, 2'd0, 2'd0, 2'd0, 32'd0,        2'd3, 6'd63, 64'd2709},
    {K_NOP,  2'd2, 2'd0, 2'd0, 2'd0, 32'd0,        2'd3, 6'd0,  64'd400},
    {K_REST, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0,        2'd1, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF},
    {K_IMM,  2'd3, 2'd0, 2'd0, 2'd0, 32'h0001_0001, 2'd0, 6'd0, 64'd0},
    {K_MUL,  2'd3, 2'd3, 2'd3, 2'd0, 32'd0,        2'd3, 6'd7,  64'h0002_0001},
    {K_IMM,  2'd3, 2'd0, 2'd0, 2'd0, 32'hFFFF_FFFF, 2'd3, 6'd40, 64'hFFFF_FFFF},
    {K_CMP,  2'd0, 2'd3, 2'd1, 2'd0, 32'd0,        2'd2, 6'd0,  64'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] vd, input logic [1:0] va,
                       input logic [1:0] vb, input logic [1:0] sd, input logic [31:0] imm,
                       input logic [7:0] tgt);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_vd = vd; in_va = va; in_vb = vb;
    in_sd = sd; in_imm = imm; in_target = tgt;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic peek(input logic [1:0] r, input logic [5:0] e, output logic [31:0] d);
    rd_vreg = r; rd_lane = e;
    #1;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; in_valid = 1'b0; in_op = K_NOP; in_vd = '0; in_va = '0; in_vb = '0;
    in_sd = '0; in_imm = '0; in_target = '0; rd_vreg = '0; rd_lane = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check("R1 exec", exec_mask, '1);
    check("R1 vcc", vcc_mask, '0);
    check("R1 ready", {63'd0, in_ready}, 64'd1);
    check("R1 branch", {63'd0, branch_taken}, 64'd0);

    // divergent if/else program table
    for (int k = 0; k < NT; k++) begin
      logic [115:0] ent;
      ent = PROG[k];
      if (ent[115:112] != K_NOP) begin
        issue(ent[115:112], ent[111:110], ent[109:108], ent[107:106], ent[105:104],
              ent[103:72], 8'd0);
        if (ent[115:112] >= K_CMP && ent[115:112] <= K_IDX) repeat (4) @(negedge clk);
      end
      case (ent[71:70])
        2'd1: check("R7 R8 R9 exec", exec_mask, ent[63:0]);
        2'd2: check("R3 vcc", vcc_mask, ent[63:0]);
        2'd3: begin
          peek(ent[111:110], ent[69:64], d);
          check("R4 R5 R6 R12 lane data", {32'd0, d}, ent[63:0]);
        end
        default: ;
      endcase
    end

    // R10 skip-branch with no active lane (vcc is zero here)
    issue(K_IF, 2'd0, 2'd0, 2'd0, 2'd1, 32'd0, 8'd0);
    check("R7 exec emptied", exec_mask, '0);
    issue(K_BRZ, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0, 8'h5A);
    check("R10 taken", {63'd0, branch_taken}, 64'd1);
    check("R10 target", {56'd0, branch_target}, 64'h5A);
    @(negedge clk);
    check("R10 one cycle pulse", {63'd0, branch_taken}, 64'd0);
    // R6 fill with every lane inactive leaves data untouched
    issue(K_IMM, 2'd0, 2'd0, 2'd0, 2'd0, 32'd7, 8'd0);
    repeat (4) @(negedge clk);
    peek(2'd0, 6'd0, d);
    check("R6 masked fill lane0", {32'd0, d}, 64'd0);
    peek(2'd0, 6'd50, d);
    check("R6 masked fill lane50", {32'd0, d}, 64'd50);
    issue(K_REST, 2'd0, 2'd0, 2'd0, 2'd1, 32'd0, 8'd0);
    check("R9 restore", exec_mask, '1);
    issue(K_BRZ, 2'd0, 2'd0, 2'd0, 2'd0, 32'd0, 8'h33);
    check("R10 not taken", {63'd0, branch_taken}, 64'd0);
    check("R2 scalar keeps ready", {63'd0, in_ready}, 64'd1);

    // R11 compare commit and "if" on the same edge
    @(negedge clk);
    in_valid = 1'b1; in_op = K_CMP; in_va = 2'd1; in_vb = 2'd0;
    @(posedge clk);
    @(negedge clk);
    in_op = K_IF; in_sd = 2'd2;
    check("R2 ready low 1", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    check("R2 ready low 2", {63'd0, in_ready}, 64'd0);
    check("R11 vcc held mid compare", vcc_mask, '0);
    @(negedge clk);
    check("R2 ready low 3", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    check("R2 ready back", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 vcc committed", vcc_mask, 64'h0000_0000_000F_FFFF);
    check("R11 if sees new vcc", exec_mask, 64'h0000_0000_000F_FFFF);
    issue(K_REST, 2'd0, 2'd0, 2'd0, 2'd2, 32'd0, 8'd0);
    check("R9 restore after forward", exec_mask, '1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule